// File: doc/BRIEF.md
# Free-Running Timestamp Counter

The block keeps a count that starts at zero when reset is released and then advances at a fixed rate of 307,200 counts per second. The rate is independent of the system clock frequency. A fractional prescaler turns the system clock into a one-cycle advance enable. It adds the target rate to a phase accumulator on every clock. When the accumulator passes the system clock frequency, it subtracts that frequency and raises the enable. The remainder is carried forward, so the long-term rate carries no drift.

Software reads the count over a 16-bit bus using a byte offset within the block's small address window.

- Offset 0 returns the low sixteen bits of the count.
- Offset 2 returns count bits 23:8. This window overlaps the first, so a coarse timestamp with 256-count resolution is available in a single read.
- Every other offset in the window returns all ones.

The block has no write path. The count cannot be loaded, and the block raises no interrupt.

Top module: `tstamp_counter`

## Requirements
- R1: While reset is asserted and before the first read, rdata_o is 0. A read issued on the first clock after reset release returns a count of 0.
- R2: After N rising clock edges since reset release, the count equals floor(N * TICK_HZ / SYS_CLK_HZ). It advances by exactly one on an edge where the prescaler enable is high and holds on every other edge.
- R3: A read at byte offset 0 returns count bits 15:0.
- R4: A read at byte offset 2 returns count bits 23:8.
- R5: A read at any offset of the window other than 0 and 2 returns 16'hFFFF.
- R6: rdata_o is loaded on the rising edge that samples rd_i high, from the count held before that edge. rdata_o holds its value while rd_i is low, whatever addr_i does.
- R7: The count never changes by more than one between consecutive clock edges, and it never decreases before it wraps at 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock of frequency SYS_CLK_HZ |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Read strobe, sampled on the rising edge |
| addr_i | input | ADDR_W | Byte offset within the block's window |
| rdata_o | output | 16 | Registered read data |

## Verification
A wrong accumulator remainder or a missed carry shows up as drift. After a few hundred cycles, the low word read back moves off floor(N * TICK_HZ / SYS_CLK_HZ), and the error grows linearly with time. A counter that skips or repeats a value is visible at the low word within a few reads. A wrong high window only becomes visible once the count passes 256, which takes about 830 cycles in the small configuration. A swapped or stuck read multiplexer shows on the very next read at the affected offset.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  localparam int WORD_W    = 16;
  localparam int LO_OFS    = 0;
  localparam int HI_OFS    = 2;
  localparam int HI_SHIFT  = 8;
  localparam logic [WORD_W-1:0] IDLE_WORD = '1;
  localparam int MIN_CNT_W = HI_SHIFT + WORD_W;
endpackage

// File: rtl/tstamp_prescaler.sv
module tstamp_prescaler #(
  parameter int unsigned SYS_CLK_HZ = 250_000_000,
  parameter int unsigned TICK_HZ    = 307_200
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int ACC_W = $clog2(SYS_CLK_HZ) + 1;
  localparam logic [ACC_W-1:0] INC_V = ACC_W'(TICK_HZ);
  localparam logic [ACC_W-1:0] MOD_V = ACC_W'(SYS_CLK_HZ);

  logic [ACC_W-1:0] acc_q, acc_d, sum;

  always_comb begin
    sum    = acc_q + INC_V;
    tick_o = (sum >= MOD_V);
    acc_d  = tick_o ? sum - MOD_V : sum;  // remainder kept: no drift
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end
endmodule

// File: rtl/tstamp_count.sv
module tstamp_count #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_o <= '0;
    else if (tick_i) count_o <= count_o + 1'b1;  // silent wrap
  end
endmodule

// File: rtl/tstamp_rdmux.sv
module tstamp_rdmux
  import tstamp_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] sel;

  always_comb begin
    if (addr_i == ADDR_W'(LO_OFS))      sel = count_i[WORD_W-1:0];
    else if (addr_i == ADDR_W'(HI_OFS)) sel = count_i[HI_SHIFT +: WORD_W];
    else                                sel = IDLE_WORD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= sel;
  end
endmodule

// File: rtl/tstamp_counter.sv
module tstamp_counter
  import tstamp_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ = 250_000_000,
  parameter int unsigned TICK_HZ    = 307_200,
  parameter int          CNT_W      = 24,
  parameter int          ADDR_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [15:0]       rdata_o
);
  logic             tick;
  logic [CNT_W-1:0] count_q;

  tstamp_prescaler #(.SYS_CLK_HZ(SYS_CLK_HZ), .TICK_HZ(TICK_HZ)) presc_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  tstamp_count #(.CNT_W(CNT_W)) cnt_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .count_o(count_q)
  );

  tstamp_rdmux #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) mux_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_i),
    .addr_i (addr_i),
    .count_i(count_q),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/tstamp_counter_chk.sv
module tstamp_counter_chk
  import tstamp_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [15:0]       rdata_o,
  input logic              tick,
  input logic [CNT_W-1:0]  count_q
);
  AST_TICK_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> count_q == $past(count_q) + 1'b1);  // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(count_q));  // R2
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q != $past(count_q)) |-> (count_q == $past(count_q) + 1'b1));  // R7
  AST_READ_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(LO_OFS)) |=> rdata_o == $past(count_q[15:0]));  // R3
  AST_READ_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(HI_OFS)) |=> rdata_o == $past(count_q[HI_SHIFT +: 16]));  // R4
  AST_READ_OTHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i != ADDR_W'(LO_OFS) && addr_i != ADDR_W'(HI_OFS)) |=> rdata_o == 16'hFFFF);  // R5
  AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));  // R6
endmodule

bind tstamp_counter tstamp_counter_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rd_i   (rd_i),
  .addr_i (addr_i),
  .rdata_o(rdata_o),
  .tick   (tick),
  .count_q(count_q)
);

// File: tb/tstamp_counter_tb_top.sv
module tstamp_counter_tb_top;
  localparam int unsigned SYS_HZ = 1_000_000;
  localparam int unsigned TCK_HZ = 307_200;
  localparam int CW = 24;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   rdata;
  longint        edges;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;

  tstamp_counter #(.SYS_CLK_HZ(SYS_HZ), .TICK_HZ(TCK_HZ), .CNT_W(CW), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .addr_i(addr), .rdata_o(rdata)
  );

  function automatic logic [15:0] expect_word(int a, longint e);
    longint c = ((e - 1) * TCK_HZ / SYS_HZ) % (longint'(1) << CW);
    if (a == 0)      return c[15:0];
    else if (a == 2) return c[23:8];
    else             return 16'hFFFF;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(int a, output logic [15:0] d, output longint e);
    rd = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd = 1'b0;
    d = rdata; e = edges;
  endtask

  initial begin
    logic [15:0] d, prev, held;
    longint e;
    #1;
    check("R1 in reset", rdata, 16'h0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 after release", rdata, 16'h0000);
    do_read(0, d, e);
    check("R1 first read", d, 16'h0000);
    for (int i = 0; i < 3000; i++) begin
      do_read(i % 8, d, e);
      case (i % 8)
        0:       check("R3 R2 low word", d, expect_word(0, e));
        2:       check("R4 R2 high word", d, expect_word(2, e));
        default: check("R5 other offset", d, expect_word(i % 8, e));
      endcase
      if (i % 7 == 0) begin
        held = d;
        for (int k = 0; k < 3; k++) begin
          addr = AW'(k + i);
          @(negedge clk);
          check("R6 hold", rdata, held);
        end
      end
    end
    do_read(0, prev, e);
    for (int i = 0; i < 50; i++) begin
      do_read(0, d, e);
      check("R7 step", ((d - prev) <= 16'd1) ? 16'd1 : 16'd0, 16'd1);
      check("R2 back-to-back", d, expect_word(0, e));
      prev = d;
    end
    repeat (40000) @(negedge clk);
    do_read(0, d, e);
    check("R2 long run low", d, expect_word(0, e));
    do_read(2, d, e);
    check("R4 long run high", d, expect_word(2, e));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150_000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule